// File: doc/BRIEF.md
# Serial bus receive bit destuffer with 15-bit CRC check

This block sits between the bit timing logic and the frame parser of a serial bus receiver. Each sampled bus bit arrives with a one-cycle valid strobe. Inside the protected window of a frame, the window opens at the start-of-frame bit and closes after the 15-bit CRC field. In that window the block drops the inserted stuff bits and flags any break of the stuffing rule. Every other bit it forwards on a destuffed output stream, which has its own valid strobe.

The header and data bits that survive destuffing are folded into a 15-bit CRC register, one bit at a time. The outside parser marks two points in the frame. It raises a frame-start input together with the start-of-frame bit, and a field-end input together with the last bit of the data field, or with the last length-code bit when the frame carries no data. The next 15 delivered bits are taken as the received CRC, most significant bit first. After the fifteenth of them the block compares the two values and closes the window. Bits outside the window, such as the delimiter, acknowledge, end-of-frame and intermission bits, pass through untouched.

Top module: `canrx_unstuff_crc`

## Requirements
- R1: While reset is held and in the first cycle after it, out_vld, out_bit, stuff_err and crc_err are all 0.
- R2: While no window is open, every bit that comes with in_vld appears on out_bit with out_vld=1. No bit is removed, however long the run of equal bits, and stuff_err stays 0.
- R3: A bit that comes with in_vld and sof_mark=1 is taken as the start-of-frame bit, and it is forwarded. It opens the window even when a window is already open. It sets the run count to 1, with a dominant (0) previous bit, and it clears the CRC register before that bit is folded in.
- R4: Inside the window, once five delivered bits of equal value have gone by, the next bit is a stuff bit. If its value is opposite, it is dropped (out_vld=0). It counts as the first bit of a new run, so four further equal bits call for another stuff bit.
- R5: If the bit in a stuff slot has the same value as the run before it, stuff_err is 1 for exactly one cycle. That bit is not forwarded, the window closes, and the bits that follow pass through as in R2.
- R6: Each forwarded bit shows on out_bit and out_vld in the clock cycle after the one in which it came with in_vld. The order of bits is kept, and with in_vld low nothing is forwarded.
- R7: The CRC generator polynomial is 0x4599, that is x^15+x^14+x^10+x^8+x^7+x^4+x^3+1. The register is shifted MSB first, and its feedback is the incoming bit XOR bit 14. It covers the delivered bits from the start-of-frame bit up to and including the bit marked by field_end. It never includes stuff bits or the CRC field.
- R8: After the field_end bit, the next 15 delivered bits are the received CRC, MSB first. Together with the 15th of them, the window closes. crc_err is 1 for exactly one cycle, in the same cycle that this bit shows on out_vld, if the received and computed values differ. If they match, crc_err stays 0.
- R9: No stuff bit is expected after the last CRC bit. The recessive bits that follow the CRC field are all forwarded, even when they extend a run past five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_bit | input | 1 | Sampled bus bit (0 = dominant) |
| in_vld | input | 1 | One-cycle strobe: in_bit holds a new bit |
| sof_mark | input | 1 | With in_vld: this bit is the start-of-frame bit |
| field_end | input | 1 | With in_vld: this is the last bit covered by the CRC |
| out_bit | output | 1 | Destuffed bit |
| out_vld | output | 1 | One-cycle strobe for out_bit |
| stuff_err | output | 1 | One-cycle pulse on a stuffing rule violation |
| crc_err | output | 1 | One-cycle pulse when the received CRC differs |

## Verification
A run counter off by one shows up either as a dropped bit that should have been forwarded, or as a stuff bit leaking onto out_vld. This is visible in the same cycle as the first frame position where five equal bits meet, which is often within the first six bits of a dominant identifier. If the CRC register drifts, or a stuff bit is folded into it, nothing shows until the 15th CRC bit, where crc_err fires on a good frame. Wrong window control shows either as stuff bits removed from the trailing recessive bits, or as a stuff slot missing in the CRC field.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BODY = 2'd1,
        PH_CRC  = 2'd2
    } phase_e;

endpackage

// File: rtl/canrx_run_track.sv
module canrx_run_track #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic advance,
    input  logic bit_i,
    output logic stuff_slot,
    output logic same_as_prev
);
    localparam int CW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } run_t;

    run_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            // start-of-frame bit: dominant previous, run of one
            st_d.prev = 1'b0;
            st_d.cnt  = CW'(1);
        end else if (advance) begin
            if ((bit_i == st_q.prev) && (st_q.cnt < CW'(RUN_LEN)))
                st_d.cnt = st_q.cnt + CW'(1);
            else
                st_d.cnt = CW'(1);
            st_d.prev = bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b0;
            st_q.cnt  <= CW'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign stuff_slot   = (st_q.cnt == CW'(RUN_LEN));
    assign same_as_prev = (bit_i == st_q.prev);

    // R4: run length always within 1..RUN_LEN
    p_run_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt >= CW'(1)) && (st_q.cnt <= CW'(RUN_LEN)));

    // R3: a restart leaves a run of one with dominant history
    p_restart_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == CW'(1)) && !st_q.prev);

endmodule

// File: rtl/canrx_crc_gen.sv
module canrx_crc_gen #(
    parameter int                CRC_W    = 15,
    parameter logic [CRC_W-1:0]  CRC_POLY = 15'h4599
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_i,
    output logic [CRC_W-1:0] crc_o
);
    logic [CRC_W-1:0] crc_d, crc_q;
    logic [CRC_W-1:0] base;
    logic             fb;

    always_comb begin
        base  = clear ? '0 : crc_q;
        fb    = bit_i ^ base[CRC_W-1];
        crc_d = crc_q;
        if (clear || shift)
            crc_d = {base[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;

    // R7: register moves only when a bit is folded in or a frame starts
    p_crc_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !shift) |=> $stable(crc_q));

endmodule

// File: rtl/canrx_unstuff_crc.sv
module canrx_unstuff_crc #(
    parameter int               RUN_LEN  = 5,
    parameter int               CRC_W    = 15,
    parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_bit,
    input  logic in_vld,
    input  logic sof_mark,
    input  logic field_end,
    output logic out_bit,
    output logic out_vld,
    output logic stuff_err,
    output logic crc_err
);
    import canrx_pkg::*;

    localparam int NW = $clog2(CRC_W + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CRC_W-1:0] rx_crc;
        logic [NW-1:0]    rx_cnt;
        logic             obit;
        logic             ovld;
        logic             serr;
        logic             cerr;
    } top_t;

    top_t st_d, st_q;

    logic             run_restart, run_adv, stuff_slot, same_as_prev;
    logic             crc_clr, crc_shift;
    logic [CRC_W-1:0] crc_val;
    logic [CRC_W-1:0] rx_next;

    canrx_run_track #(.RUN_LEN(RUN_LEN)) run_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart      (run_restart),
        .advance      (run_adv),
        .bit_i        (in_bit),
        .stuff_slot   (stuff_slot),
        .same_as_prev (same_as_prev)
    );

    canrx_crc_gen #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clr),
        .shift (crc_shift),
        .bit_i (in_bit),
        .crc_o (crc_val)
    );

    assign rx_next = {st_q.rx_crc[CRC_W-2:0], in_bit};

    always_comb begin
        st_d        = st_q;
        st_d.ovld   = 1'b0;
        st_d.serr   = 1'b0;
        st_d.cerr   = 1'b0;
        run_restart = 1'b0;
        run_adv     = 1'b0;
        crc_clr     = 1'b0;
        crc_shift   = 1'b0;

        if (in_vld) begin
            if (sof_mark) begin
                st_d.phase  = PH_BODY;
                st_d.rx_cnt = '0;
                st_d.obit   = in_bit;
                st_d.ovld   = 1'b1;
                run_restart = 1'b1;
                crc_clr     = 1'b1;
            end else begin
                case (st_q.phase)
                    PH_BODY, PH_CRC: begin
                        run_adv = 1'b1;
                        if (stuff_slot) begin
                            if (same_as_prev) begin
                                st_d.serr  = 1'b1;
                                st_d.phase = PH_IDLE;
                            end
                        end else begin
                            st_d.obit = in_bit;
                            st_d.ovld = 1'b1;
                            if (st_q.phase == PH_BODY) begin
                                crc_shift = 1'b1;
                                if (field_end) begin
                                    st_d.phase  = PH_CRC;
                                    st_d.rx_cnt = '0;
                                end
                            end else begin
                                st_d.rx_crc = rx_next;
                                st_d.rx_cnt = st_q.rx_cnt + NW'(1);
                                if (st_q.rx_cnt == NW'(CRC_W - 1)) begin
                                    st_d.phase = PH_IDLE;
                                    st_d.cerr  = (rx_next != crc_val);
                                end
                            end
                        end
                    end
                    default: begin
                        st_d.obit = in_bit;
                        st_d.ovld = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.rx_crc <= '0;
            st_q.rx_cnt <= '0;
            st_q.obit   <= 1'b0;
            st_q.ovld   <= 1'b0;
            st_q.serr   <= 1'b0;
            st_q.cerr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_bit   = st_q.obit;
    assign out_vld   = st_q.ovld;
    assign stuff_err = st_q.serr;
    assign crc_err   = st_q.cerr;

    // R5: a violating bit is never forwarded
    p_serr_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |-> !out_vld);

    // R5: stuff error is a single-cycle pulse
    p_serr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |=> !stuff_err);

    // R8: CRC error is a single-cycle pulse, tied to a forwarded bit
    p_cerr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> !crc_err);
    p_cerr_with_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> out_vld);

    // R6: output strobe only follows an input strobe
    p_out_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> $past(in_vld));

    // R7: computed CRC is frozen while the CRC field is received
    p_crc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CRC && $past(st_q.phase) == PH_CRC) |-> $stable(crc_val));

endmodule

// File: tb/canrx_unstuff_crc_tb.sv
module canrx_unstuff_crc_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_bit = 1'b0, in_vld = 1'b0, sof_mark = 1'b0, field_end = 1'b0;
    logic out_bit, out_vld, stuff_err, crc_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic raw [0:159];
    int   nraw;
    int   de_idx;

    always #10 clk = ~clk;

    canrx_unstuff_crc dut_i (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_vld(in_vld),
        .sof_mark(sof_mark), .field_end(field_end),
        .out_bit(out_bit), .out_vld(out_vld),
        .stuff_err(stuff_err), .crc_err(crc_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic b, input logic fs, input logic de,
                        input logic ev, input logic eb, input logic es,
                        input logic ec, input string req);
        @(negedge clk);
        in_bit = b; in_vld = 1'b1; sof_mark = fs; field_end = de;
        @(negedge clk);
        in_vld = 1'b0; sof_mark = 1'b0; field_end = 1'b0;
        check({req, " out_vld"}, int'(out_vld), int'(ev));
        if (ev) check({req, " out_bit"}, int'(out_bit), int'(eb));
        check({req, " stuff_err"}, int'(stuff_err), int'(es));
        check({req, " crc_err"}, int'(crc_err), int'(ec));
    endtask

    task automatic push(input logic b);
        raw[nraw] = b;
        nraw++;
    endtask

    task automatic run_frame(input bit ext, input logic [28:0] id, input bit rtr,
                             input int dlc, input int seed, input bit corrupt);
        int nbytes;
        logic [14:0] c;
        logic prev;
        int run;
        nraw = 0;
        push(1'b0);
        if (ext) begin
            for (int i = 28; i >= 18; i--) push(id[i]);
            push(1'b1); push(1'b1);
            for (int i = 17; i >= 0; i--) push(id[i]);
            push(rtr); push(1'b0); push(1'b0);
        end else begin
            for (int i = 10; i >= 0; i--) push(id[i]);
            push(rtr); push(1'b0); push(1'b0);
        end
        for (int i = 3; i >= 0; i--) push(dlc[i]);
        nbytes = rtr ? 0 : (dlc > 8 ? 8 : dlc);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] by;
            by = 8'((seed * 29 + k * 71 + dlc * 13) & 255);
            if (seed == 0) by = 8'h00;
            for (int i = 7; i >= 0; i--) push(by[i]);
        end
        de_idx = nraw - 1;
        // R7: reference CRC over SOF..data, MSB first
        c = '0;
        for (int i = 0; i < nraw; i++) begin
            logic fb;
            fb = raw[i] ^ c[14];
            c = {c[13:0], 1'b0};
            if (fb) c = c ^ 15'h4599;
        end
        if (corrupt) c[7] = ~c[7];
        for (int i = 14; i >= 0; i--) push(c[i]);
        prev = 1'b0;
        run = 0;
        for (int i = 0; i < nraw; i++) begin
            if (i > 0 && run == 5) begin
                send(~prev, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 stuff drop");
                prev = ~prev;
                run = 1;
            end
            send(raw[i], (i == 0), (i == de_idx), 1'b1, raw[i], 1'b0,
                 (i == nraw - 1) ? corrupt : 1'b0, "R6/R7/R8 frame bit");
            if (raw[i] == prev) run++; else run = 1;
            prev = raw[i];
        end
        // R9: trailing recessive bits pass untouched
        for (int i = 0; i < 13; i++)
            send(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 trailer");
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_vld", int'(out_vld), 0);
        check("R1 stuff_err", int'(stuff_err), 0);
        check("R1 crc_err", int'(crc_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_vld post", int'(out_vld), 0);
        check("R1 out_bit post", int'(out_bit), 0);

        // R2: idle pass-through, long runs kept
        for (int i = 0; i < 8; i++)
            send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 idle zeros");
        send(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2 idle one");

        // R4: stuff bit starts a new run
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 sof");
        for (int i = 0; i < 4; i++)
            send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 run");
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 stuff one");
        for (int i = 0; i < 4; i++)
            send(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 new run");
        send(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 second stuff");

        // R5: violation after stuff-started run
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 sof");
        for (int i = 0; i < 4; i++)
            send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 run");
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R4 stuff one");
        for (int i = 0; i < 4; i++)
            send(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4 new run");
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5 sixth equal");
        for (int i = 0; i < 7; i++)
            send(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R5 window closed");

        // R3: frame start inside an open window restarts the run
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 sof");
        for (int i = 0; i < 3; i++)
            send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 pre");
        send(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 resof");
        for (int i = 0; i < 4; i++)
            send(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 run");
        send(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 stuff after restart");

        // R7/R8/R9: frame sweep, both header formats, all lengths
        for (int ext = 0; ext < 2; ext++)
            for (int dlc = 0; dlc <= 8; dlc++)
                for (int seed = 0; seed < 3; seed++) begin
                    logic [28:0] id;
                    if (seed == 0)      id = 29'h0;
                    else if (seed == 1) id = ext ? 29'h1FFFFFFF : 29'h7FF;
                    else                id = 29'((dlc * 123457 + 991) & (ext ? 32'h1FFFFFFF : 32'h7FF));
                    run_frame(ext[0], id, (seed == 2 && dlc == 3),
                              dlc, seed, (seed == 1 && (dlc % 3) == 0));
                end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule